// File: doc/BRIEF.md
# Receive Slot Ring Writer

This block takes received Ethernet frames from a port-side stream and writes each one into a fixed-size slot of a ring of host-memory buffers. Software reserves the ring before traffic starts. It gives the block a base address and a slot count. From then on the hardware hands out slots and takes them back in strict circular order, so software never allocates a buffer per packet.

Each slot is a single record that holds both the buffer and its descriptor. At the start of the slot is a 64-byte metadata area. Next comes a 64-byte area reserved for a flow key, which a neighbouring parser fills. The frame bytes come last. The metadata gives the slot's own address, the stored length, the ingress port, a truncation flag, the address of the slot software should poll next, and a ready flag. The ready flag is the final write for a slot. A host thread can therefore follow the chain by polling ready flags alone.

Software gives a slot back by presenting its index on the release input. A release must name the oldest slot still in use. When every slot is occupied, a new frame is discarded whole and counted.

Top module: `rx_slot_ring_writer`

## Requirements
- R1: After reset, in_ready is 1, mem_wr_en is 0, drop_count is 0 and rel_err is 0.
- R2: Frame beat i (8 bytes, 64-bit little-endian word) of a stored frame is written to base + slot*2048 + 128 + 8*i.
- R3: Frames fill slots in the order 0, 1, ..., cfg_slots-1, then wrap back to slot 0.
- R4: The header word at slot offset 0 holds the slot address in bits [31:0], the stored byte count in [47:32], the ingress port in [51:48] and a truncation flag in bit 52. The stored byte count is 8 per full beat plus in_last_bytes (1..8) for the last beat.
- R5: The header word at slot offset 8 holds the next slot's address in bits [31:0] and a ready flag of 1 in bit 63. It is the last write for that slot and follows the offset-0 write in the immediately preceding cycle.
- R6: After the last beat of a stored frame, in_ready stays low for exactly two cycles and then returns high.
- R7: When all cfg_slots slots are in use, an arriving frame produces no memory writes, drop_count rises by exactly 1, and in_ready stays high.
- R8: A release whose index equals the oldest slot in use frees that slot. A release with any other index, or one made while no slot is in use, frees nothing and raises rel_err for exactly one cycle.
- R9: Only the first 240 beats of a frame are stored. When a frame has more beats than that, the stored byte count is 1920 and the truncation flag is 1. A frame of exactly 240 beats has the truncation flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 32 | Byte address of slot 0 (2048-aligned) |
| cfg_slots | input | 5 | Number of slots in the ring |
| in_valid | input | 1 | Frame beat present |
| in_ready | output | 1 | Block accepts a beat |
| in_data | input | 64 | Frame beat |
| in_last | input | 1 | Last beat of the frame |
| in_last_bytes | input | 4 | Valid bytes in the last beat, 1..8 |
| in_port | input | 4 | Ingress port, sampled on the first beat |
| rel_valid | input | 1 | Software returns a slot |
| rel_idx | input | 4 | Index of the returned slot |
| rel_err | output | 1 | Rejected release, one-cycle pulse |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 64 | Memory write data |
| drop_count | output | 16 | Frames discarded for lack of a slot |

## Verification
The bench sweeps frame lengths and last-beat byte counts across every slot of a four-slot ring. Each frame is checked word by word against a model of host memory. The bench also checks that the ready word comes last and that the next pointer wraps from the final slot back to slot 0. An off-by-one in the wrap would send software to a slot outside the ring. Writing the ready flag too early would show up as a non-final write.

The bench fills the ring and sends further frames, which must vanish without a single write and be counted. It then makes an out-of-order release and a release on an empty ring; a design that accepted these would reuse a slot software still owns. Frames of exactly 240 and of 245 beats probe the truncation limit, where a wrong comparison either drops the last word or overruns into the next slot.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int DATA_W     = 64;
  localparam int ADDR_W     = 32;
  localparam int LEN_W      = 16;
  localparam int PORT_W     = 4;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int META_OFF   = 0;
  localparam int LINK_OFF   = 8;
  localparam int KEY_OFF    = 64;
  localparam int DATA_OFF   = 128;

  typedef enum logic [1:0] {S_ACCEPT, S_HDR0, S_HDR1} wr_state_t;

  function automatic logic [DATA_W-1:0] pack_hdr0(
      input logic [ADDR_W-1:0] addr, input logic [LEN_W-1:0] len,
      input logic [PORT_W-1:0] port, input logic trunc);
    logic [DATA_W-1:0] w;
    w = '0;
    w[31:0]  = addr;
    w[47:32] = len;
    w[51:48] = port;
    w[52]    = trunc;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_link(input logic [ADDR_W-1:0] nxt);
    logic [DATA_W-1:0] w;
    w = '0;
    w[31:0] = nxt;
    w[63]   = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/rxb_slot_ring.sv
module rxb_slot_ring #(
  parameter int MAX_SLOTS = 16,
  localparam int IDX_W = $clog2(MAX_SLOTS),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_slots,
  input  logic             commit,
  input  logic             rel_valid,
  input  logic [IDX_W-1:0] rel_idx,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             full,
  output logic             rel_err
);
  logic [IDX_W-1:0] rd_idx;
  logic [CNT_W-1:0] used;
  logic             rel_ok;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i,
                                             input logic [CNT_W-1:0] n);
    return ({1'b0, i} + CNT_W'(1) >= n) ? '0 : i + IDX_W'(1);
  endfunction

  assign full    = (used >= cfg_slots);
  assign nxt_idx = step(wr_idx, cfg_slots);
  assign rel_ok  = rel_valid && (used != '0) && (rel_idx == rd_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx  <= '0;
      rd_idx  <= '0;
      used    <= '0;
      rel_err <= 1'b0;
    end else begin
      rel_err <= rel_valid && !rel_ok;
      if (commit) wr_idx <= nxt_idx;
      if (rel_ok) rd_idx <= step(rd_idx, cfg_slots);
      used <= used + CNT_W'(commit) - CNT_W'(rel_ok);
    end
  end
endmodule

// File: rtl/rxb_frame_writer.sv
module rxb_frame_writer
  import rxb_pkg::*;
#(
  parameter int SLOT_BYTES = 2048,
  parameter int IDX_W      = 4,
  parameter int DROP_W     = 16,
  localparam int SLOT_SH    = $clog2(SLOT_BYTES),
  localparam int DATA_WORDS = (SLOT_BYTES - DATA_OFF) / WORD_BYTES,
  localparam int BEAT_W     = $clog2(DATA_WORDS + 1),
  localparam int WSH        = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic [3:0]        in_last_bytes,
  input  logic [PORT_W-1:0] in_port,
  input  logic              full,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  nxt_idx,
  output logic              commit,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [DROP_W-1:0] drop_count
);
  wr_state_t         state;
  logic              in_frame, keep_q, trunc_q;
  logic [BEAT_W-1:0] beat_q;
  logic [LEN_W-1:0]  len_q;
  logic [PORT_W-1:0] port_q;

  logic              fire, start, keep_now, room;
  logic [BEAT_W-1:0] cur_beat;
  logic [LEN_W-1:0]  cur_len;
  logic [PORT_W-1:0] cur_port;
  logic [ADDR_W-1:0] slot_addr, nxt_addr;

  function automatic logic [ADDR_W-1:0] addr_of(input logic [ADDR_W-1:0] b,
                                                input logic [IDX_W-1:0] i);
    return b + (ADDR_W'(i) << SLOT_SH);
  endfunction

  assign in_ready  = (state == S_ACCEPT);
  assign commit    = (state == S_HDR1);
  assign fire      = in_valid && in_ready;
  assign start     = !in_frame;
  assign keep_now  = start ? !full : keep_q;
  assign cur_beat  = start ? '0 : beat_q;
  assign cur_len   = start ? '0 : len_q;
  assign cur_port  = start ? in_port : port_q;
  assign room      = (cur_beat < BEAT_W'(DATA_WORDS));
  assign slot_addr = addr_of(cfg_base, wr_idx);
  assign nxt_addr  = addr_of(cfg_base, nxt_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_ACCEPT;
      in_frame    <= 1'b0;
      keep_q      <= 1'b0;
      trunc_q     <= 1'b0;
      beat_q      <= '0;
      len_q       <= '0;
      port_q      <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      drop_count  <= '0;
    end else begin
      mem_wr_en <= 1'b0;
      case (state)
        S_ACCEPT: if (fire) begin
          keep_q   <= keep_now;
          port_q   <= cur_port;
          in_frame <= !in_last;
          if (start) begin
            trunc_q <= 1'b0;
            if (!keep_now) drop_count <= drop_count + DROP_W'(1);
          end
          if (room) begin
            beat_q <= cur_beat + BEAT_W'(1);
            len_q  <= cur_len + LEN_W'(in_last ? in_last_bytes : 4'd8);
            if (keep_now) begin
              mem_wr_en   <= 1'b1;
              mem_wr_addr <= slot_addr + ADDR_W'(DATA_OFF) + (ADDR_W'(cur_beat) << WSH);
              mem_wr_data <= in_data;
            end
          end else begin
            beat_q  <= cur_beat;
            len_q   <= cur_len;
            trunc_q <= 1'b1;
          end
          if (in_last && keep_now) state <= S_HDR0;
        end
        S_HDR0: begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= slot_addr + ADDR_W'(META_OFF);
          mem_wr_data <= pack_hdr0(slot_addr, len_q, port_q, trunc_q);
          state       <= S_HDR1;
        end
        S_HDR1: begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= slot_addr + ADDR_W'(LINK_OFF);
          mem_wr_data <= pack_link(nxt_addr);
          state       <= S_ACCEPT;
        end
        default: state <= S_ACCEPT;
      endcase
    end
  end
endmodule

// File: rtl/rx_slot_ring_writer.sv
module rx_slot_ring_writer
  import rxb_pkg::*;
#(
  parameter int SLOT_BYTES = 2048,
  parameter int MAX_SLOTS  = 16,
  parameter int DROP_W     = 16,
  localparam int IDX_W = $clog2(MAX_SLOTS),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_slots,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic [3:0]        in_last_bytes,
  input  logic [PORT_W-1:0] in_port,
  input  logic              rel_valid,
  input  logic [IDX_W-1:0]  rel_idx,
  output logic              rel_err,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [DROP_W-1:0] drop_count
);
  logic [IDX_W-1:0] wr_idx, nxt_idx;
  logic             full, commit;

  rxb_slot_ring #(.MAX_SLOTS(MAX_SLOTS)) u_ring (
    .clk(clk), .rst(rst), .cfg_slots(cfg_slots), .commit(commit),
    .rel_valid(rel_valid), .rel_idx(rel_idx), .wr_idx(wr_idx),
    .nxt_idx(nxt_idx), .full(full), .rel_err(rel_err)
  );

  rxb_frame_writer #(.SLOT_BYTES(SLOT_BYTES), .IDX_W(IDX_W), .DROP_W(DROP_W)) u_wr (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_last_bytes(in_last_bytes), .in_port(in_port), .full(full),
    .wr_idx(wr_idx), .nxt_idx(nxt_idx), .commit(commit),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .drop_count(drop_count)
  );
endmodule

// File: rtl/rx_slot_ring_writer_chk.sv
module rx_slot_ring_writer_chk #(
  parameter int SLOT_BYTES = 2048,
  parameter int CNT_W      = 5,
  parameter int DROP_W     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       cfg_base,
  input logic [CNT_W-1:0]  cfg_slots,
  input logic              in_ready,
  input logic              rel_valid,
  input logic              rel_err,
  input logic              mem_wr_en,
  input logic [31:0]       mem_wr_addr,
  input logic [63:0]       mem_wr_data,
  input logic [DROP_W-1:0] drop_count
);
  logic [31:0] off, ring_end;
  assign off      = (mem_wr_addr - cfg_base) & 32'(SLOT_BYTES - 1);
  assign ring_end = cfg_base + 32'(cfg_slots) * 32'(SLOT_BYTES);

  // R2: every write lands inside the configured ring
  a_r2_in_ring: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_wr_addr >= cfg_base && mem_wr_addr < ring_end));

  // R5: ready word follows the offset-0 header word of the same slot
  a_r5_link_after_hdr: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && off == 32'd8) |->
      ($past(mem_wr_en) && $past(mem_wr_addr) == mem_wr_addr - 32'd8 && mem_wr_data[63]));

  // R6: while the headers are written no beat is accepted
  a_r6_hold_ready: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && off == 32'd0) |-> !in_ready);

  // R7: the drop counter never moves by more than one
  a_r7_drop_step: assert property (@(posedge clk) disable iff (rst)
    (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + DROP_W'(1)));

  // R8: a rejection flag only answers a release
  a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
    rel_err |-> $past(rel_valid));
endmodule

bind rx_slot_ring_writer rx_slot_ring_writer_chk #(
  .SLOT_BYTES(SLOT_BYTES), .CNT_W(CNT_W), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_slots(cfg_slots),
  .in_ready(in_ready), .rel_valid(rel_valid), .rel_err(rel_err),
  .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data), .drop_count(drop_count)
);

// File: tb/rx_slot_ring_writer_tb.sv
module rx_slot_ring_writer_tb;
  localparam int NS    = 4;
  localparam int WPS   = 256;
  localparam int DW    = 240;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] cfg_base = BASE;
  logic [4:0]  cfg_slots = 5'(NS);
  logic in_valid = 0, in_last = 0, rel_valid = 0;
  logic [63:0] in_data = '0;
  logic [3:0]  in_last_bytes = 4'd8, in_port = '0, rel_idx = '0;
  logic in_ready, rel_err, mem_wr_en;
  logic [31:0] mem_wr_addr;
  logic [63:0] mem_wr_data;
  logic [15:0] drop_count;

  int tests = 0, fails = 0, cyc = 0, wr_count = 0;
  logic [63:0] mem [0:NS*WPS-1];
  int last_word = -1;

  always #2 clk = ~clk;

  rx_slot_ring_writer u_dut (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_slots(cfg_slots),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_last_bytes(in_last_bytes), .in_port(in_port),
    .rel_valid(rel_valid), .rel_idx(rel_idx), .rel_err(rel_err),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .drop_count(drop_count)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && mem_wr_en) begin
      int w;
      w = int'((mem_wr_addr - BASE) >> 3);
      if (w >= 0 && w < NS*WPS) mem[w] <= mem_wr_data;
      last_word <= w;
      wr_count  <= wr_count + 1;
    end
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int tag, input int beat);
    return {16'(tag), 16'hA5C3, 32'(beat)};
  endfunction

  function automatic logic [31:0] saddr(input int s);
    return BASE + 32'(s) * 32'd2048;
  endfunction

  task automatic send(input int tag, input int nb, input int lb, input int port, input bit kept);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_data = pat(tag, b); in_port = 4'(port);
      in_last = (b == nb - 1); in_last_bytes = 4'(lb);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    if (kept) begin
      check("R6 ready low 1st", {63'd0, in_ready}, 64'd0);
      @(negedge clk);
      check("R6 ready low 2nd", {63'd0, in_ready}, 64'd0);
      @(negedge clk);
      check("R6 ready back", {63'd0, in_ready}, 64'd1);
    end else begin
      check("R7 ready stays high", {63'd0, in_ready}, 64'd1);
    end
    @(negedge clk);
  endtask

  task automatic verify(input int slot, input int tag, input int nb, input int lb, input int port);
    int stored, len;
    bit tr;
    stored = (nb > DW) ? DW : nb;
    tr  = (nb > DW);
    len = tr ? DW*8 : (nb-1)*8 + lb;
    for (int i = 0; i < stored; i++)
      check($sformatf("R2 slot %0d word %0d", slot, i), mem[slot*WPS + 16 + i], pat(tag, i));
    check("R4 header word", mem[slot*WPS],
          {11'd0, tr, 4'(port), 16'(len), saddr(slot)});
    check("R5 link word", mem[slot*WPS + 1], {1'b1, 31'd0, saddr((slot + 1) % NS)});
    check("R5 link written last", 64'(last_word), 64'(slot*WPS + 1));
    check("R9 trunc flag", {63'd0, mem[slot*WPS][52]}, {63'd0, tr});
  endtask

  task automatic release_slot(input int idx, input bit expect_err);
    @(negedge clk);
    rel_valid = 1; rel_idx = 4'(idx);
    @(negedge clk);
    rel_valid = 0;
    check($sformatf("R8 release %0d err", idx), {63'd0, rel_err}, {63'd0, expect_err});
    @(negedge clk);
    check("R8 err one cycle", {63'd0, rel_err}, 64'd0);
  endtask

  initial begin
    int w0;
    for (int i = 0; i < NS*WPS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 in_ready", {63'd0, in_ready}, 64'd1);
    check("R1 mem_wr_en", {63'd0, mem_wr_en}, 64'd0);
    check("R1 drop_count", 64'(drop_count), 64'd0);
    check("R1 rel_err", {63'd0, rel_err}, 64'd0);

    // R3: sweep frame lengths and last-beat sizes through every slot
    for (int f = 0; f < NS; f++) begin
      send(f + 1, f*3 + 1, f + 5, f + 2, 1'b1);
      verify(f, f + 1, f*3 + 1, f + 5, f + 2);
    end

    // R7: ring full, frame vanishes
    w0 = wr_count;
    send(9, 5, 3, 1, 1'b0);
    check("R7 no writes when full", 64'(wr_count), 64'(w0));
    check("R7 drop counted", 64'(drop_count), 64'd1);

    // R8: out-of-order release rejected, ring still full
    release_slot(2, 1'b1);
    send(10, 2, 8, 1, 1'b0);
    check("R8 bad release freed nothing", 64'(drop_count), 64'd2);
    check("R8 no writes after bad release", 64'(wr_count), 64'(w0));

    // R3 wrap into slot 0 after correct release
    release_slot(0, 1'b0);
    send(11, 3, 1, 7, 1'b1);
    verify(0, 11, 3, 1, 7);

    for (int i = 1; i < NS; i++) release_slot(i, 1'b0);
    release_slot(0, 1'b0);
    release_slot(1, 1'b1);   // R8: ring empty

    // R9: exactly the data-area limit, then beyond it
    send(12, DW, 8, 3, 1'b1);
    verify(1, 12, DW, 8, 3);
    w0 = wr_count;
    send(13, DW + 5, 3, 4, 1'b1);
    verify(2, 13, DW + 5, 3, 4);
    check("R9 writes capped", 64'(wr_count - w0), 64'(DW + 2));
    check("R9 next slot untouched", mem[3*WPS + 16], pat(4, 0));
    check("R7 drops unchanged", 64'(drop_count), 64'd2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule